// File: doc/BRIEF.md
# Memory-Mapped Signed Decimal Display Port

This block is a write-only output port that sits on a processor's data-memory bus. It watches every store. When a store targets the one fixed port address, the block captures the 16-bit store data into a hold register. The held word is then shown as a sign flag plus five binary-coded-decimal digits. The value stays shown until the next store to the port address replaces it.

The held word is a two's complement number. A separate combinational converter turns it into sign and magnitude. It then expands the magnitude into decimal digits by repeated shift and correct steps. Because the magnitude can reach 32768, the most negative input displays correctly.

The converter has no clock, so it can be exercised apart from the bus side. The port samples the data the processor is storing, never the data read from memory.

Top module: `signed_dec_port`

## Requirements
- R1: While `rst` is high at a rising clock edge, the held word is cleared to 0x0000. Following that clear, `neg` is 0 and all five digits are 0.
- R2: A rising edge with `dm_we` high and `dm_addr` equal to 0xFFFF loads `dm_wdata` into the held word. The outputs show the new value after that edge.
- R3: A store with `dm_we` high to any address other than 0xFFFF (for example 0xFFFE or 0x7FFF) leaves the held word and all outputs unchanged.
- R4: With `dm_we` low, the held word is not changed, even when `dm_addr` is 0xFFFF.
- R5: With no qualifying store, the held word and the decoded outputs stay constant for any number of cycles.
- R6: For a held word in 0..32767, `neg` is 0. The digits give the value in decimal, with each digit a 4-bit BCD code 0..9. `dig_tenk` holds ten-thousands, then `dig_thou`, `dig_hund`, `dig_tens`, and `dig_unit` holds units.
- R7: For a held word with bit 15 set, `neg` is 1 and the digits give the magnitude. Storing -4242 (0xEF6E) gives digits 0,4,2,4,2, and storing 0xFFFF gives 0,0,0,0,1.
- R8: Storing 0x8000 gives `neg` 1 and digits 3,2,7,6,8.
- R9: When `rst` is high in the same cycle as a qualifying store, reset wins and the held word becomes 0x0000.
- R10: `held_word` always presents the raw captured 16-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high system reset |
| dm_addr | input | 16 | Data-memory address of the current access |
| dm_wdata | input | 16 | Data the processor is storing |
| dm_we | input | 1 | Store strobe |
| held_word | output | 16 | Raw captured word |
| neg | output | 1 | 1 when the held word is negative |
| dig_tenk | output | 4 | BCD ten-thousands digit |
| dig_thou | output | 4 | BCD thousands digit |
| dig_hund | output | 4 | BCD hundreds digit |
| dig_tens | output | 4 | BCD tens digit |
| dig_unit | output | 4 | BCD units digit |

## Verification
A qualifying store to 0xFFFF and the system reset can both arrive at the same rising edge, and they compete for the hold register. The bench provokes this case in three steps. It first loads a nonzero value. It then raises `rst` while a valid store of 0x1234 to the port address is on the bus. Success means the held word, the sign and every digit read zero afterwards, rather than showing 0x1234.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam int unsigned SDP_DATA_W = 16;
  localparam int unsigned SDP_NDIG   = 5;
  localparam logic [15:0] SDP_PORT_ADDR = 16'hFFFF;
  typedef logic [3:0] bcd_digit_t;
endpackage

// File: rtl/sdp_hold_reg.sv
module sdp_hold_reg #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic [DATA_W-1:0] held
);
  // Named event: a store that hits the port this cycle.
  logic wr_hit;
  assign wr_hit = we && (addr == PORT_ADDR);

  always_ff @(posedge clk) begin
    if (rst)         held <= '0;
    else if (wr_hit) held <= wdata;
  end

  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (held == $past(wdata)));

  a_r3_miss_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(held));

  a_r9_reset_wins: assert property (@(posedge clk)
    rst |=> (held == '0));
endmodule

// File: rtl/sdp_bin2bcd.sv
module sdp_bin2bcd #(
  parameter int unsigned W    = 16,
  parameter int unsigned NDIG = 5
) (
  input  logic [W-1:0]      word,
  output logic              neg,
  output logic [W-1:0]      mag,
  output logic [NDIG*4-1:0] bcd
);
  localparam int unsigned BW = NDIG * 4;

  function automatic logic [W-1:0] magnitude_of(input logic [W-1:0] v);
    return v[W-1] ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [BW-1:0] dabble(input logic [W-1:0] m);
    logic [BW+W-1:0] sr;
    sr = {{BW{1'b0}}, m};
    for (int i = 0; i < W; i++) begin
      for (int d = 0; d < NDIG; d++) begin
        if (sr[W+4*d +: 4] >= 4'd5)
          sr[W+4*d +: 4] = sr[W+4*d +: 4] + 4'd3;
      end
      sr = sr << 1;
    end
    return sr[BW+W-1:W];
  endfunction

  assign neg = word[W-1];
  assign mag = magnitude_of(word);
  assign bcd = dabble(mag);

  for (genvar g = 0; g < NDIG; g++) begin : g_digit_chk
    always_comb begin
      if (!$isunknown(bcd[4*g +: 4]))
        a_r6_digit_range: assert (bcd[4*g +: 4] <= 4'd9);
    end
  end
endmodule

// File: rtl/signed_dec_port.sv
module signed_dec_port
  import sdp_pkg::*;
#(
  parameter int unsigned DATA_W = SDP_DATA_W,
  parameter logic [15:0] PORT_ADDR = SDP_PORT_ADDR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       dm_addr,
  input  logic [DATA_W-1:0] dm_wdata,
  input  logic              dm_we,
  output logic [DATA_W-1:0] held_word,
  output logic              neg,
  output logic [3:0]        dig_tenk,
  output logic [3:0]        dig_thou,
  output logic [3:0]        dig_hund,
  output logic [3:0]        dig_tens,
  output logic [3:0]        dig_unit
);
  localparam int unsigned NDIG = SDP_NDIG;

  logic [DATA_W-1:0] mag;
  logic [NDIG*4-1:0] bcd;

  sdp_hold_reg #(.DATA_W(DATA_W), .ADDR_W(16), .PORT_ADDR(PORT_ADDR)) u_hold (
    .clk(clk), .rst(rst), .addr(dm_addr), .wdata(dm_wdata), .we(dm_we),
    .held(held_word)
  );

  sdp_bin2bcd #(.W(DATA_W), .NDIG(NDIG)) u_conv (
    .word(held_word), .neg(neg), .mag(mag), .bcd(bcd)
  );

  assign dig_unit = bcd[3:0];
  assign dig_tens = bcd[7:4];
  assign dig_hund = bcd[11:8];
  assign dig_thou = bcd[15:12];
  assign dig_tenk = bcd[19:16];

  a_r1_zero_blank: assert property (@(posedge clk) disable iff (rst)
    (held_word == '0) |-> (!neg && bcd == '0));

  a_r8_min_value: assert property (@(posedge clk) disable iff (rst)
    (held_word == {1'b1, {(DATA_W-1){1'b0}}}) |-> (neg && mag[DATA_W-1]));
endmodule

// File: tb/signed_dec_port_bench.sv
module signed_dec_port_bench;
  logic clk = 0, rst = 1, dm_we = 0;
  logic [15:0] dm_addr = 0, dm_wdata = 0, held_word;
  logic neg;
  logic [3:0] dig_tenk, dig_thou, dig_hund, dig_tens, dig_unit;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  signed_dec_port u_signed_dec_port (
    .clk(clk), .rst(rst), .dm_addr(dm_addr), .dm_wdata(dm_wdata), .dm_we(dm_we),
    .held_word(held_word), .neg(neg), .dig_tenk(dig_tenk), .dig_thou(dig_thou),
    .dig_hund(dig_hund), .dig_tens(dig_tens), .dig_unit(dig_unit)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_disp(string tag, logic [15:0] w);
    int v, m;
    v = $signed(w);
    m = (v < 0) ? -v : v;
    chk({tag, " word"}, held_word, w);
    chk({tag, " sign"}, neg, v < 0);
    chk({tag, " d4"}, dig_tenk, (m / 10000) % 10);
    chk({tag, " d3"}, dig_thou, (m / 1000) % 10);
    chk({tag, " d2"}, dig_hund, (m / 100) % 10);
    chk({tag, " d1"}, dig_tens, (m / 10) % 10);
    chk({tag, " d0"}, dig_unit, m % 10);
  endtask

  task automatic bus(logic [15:0] a, logic [15:0] d, logic we);
    @(negedge clk);
    dm_addr = a; dm_wdata = d; dm_we = we;
    @(negedge clk);
    dm_we = 0;
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    chk_disp("R1 reset", 16'h0000);
  endtask

  task automatic t_positive();
    bus(16'hFFFF, 16'd12345, 1); chk_disp("R2 R6 12345", 16'd12345);
    bus(16'hFFFF, 16'd7, 1);     chk_disp("R6 7", 16'd7);
    bus(16'hFFFF, 16'd32767, 1); chk_disp("R6 32767", 16'd32767);
    bus(16'hFFFF, 16'd0, 1);     chk_disp("R6 zero", 16'd0);
  endtask

  task automatic t_negative();
    bus(16'hFFFF, 16'hEF6E, 1);
    chk_disp("R7 -4242", 16'hEF6E);
    chk("R7 -4242 tenk literal", dig_tenk, 0);
    chk("R7 -4242 unit literal", dig_unit, 2);
    bus(16'hFFFF, 16'hFFFF, 1); chk_disp("R7 -1", 16'hFFFF);
    bus(16'hFFFF, 16'h8000, 1);
    chk_disp("R8 min", 16'h8000);
    chk("R8 tenk literal", dig_tenk, 3);
    chk("R8 unit literal", dig_unit, 8);
  endtask

  task automatic t_ignored();
    bus(16'hFFFF, 16'd999, 1);
    bus(16'hFFFE, 16'd1111, 1); chk_disp("R3 miss FFFE", 16'd999);
    bus(16'h7FFF, 16'd2222, 1); chk_disp("R3 miss 7FFF", 16'd999);
    bus(16'hFFFF, 16'd3333, 0); chk_disp("R4 we low", 16'd999);
    chk("R10 raw", held_word, 999);
  endtask

  task automatic t_persist();
    bus(16'hFFFF, 16'hD8F1, 1);
    repeat (10) @(negedge clk);
    chk_disp("R5 persist", 16'hD8F1);
  endtask

  task automatic t_collide();
    bus(16'hFFFF, 16'd4321, 1);
    @(negedge clk);
    rst = 1; dm_addr = 16'hFFFF; dm_wdata = 16'h1234; dm_we = 1;
    @(negedge clk);
    rst = 0; dm_we = 0;
    chk_disp("R9 reset wins", 16'h0000);
  endtask

  initial begin
    t_reset();
    t_positive();
    t_negative();
    t_ignored();
    t_persist();
    t_collide();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule